// File: doc/BRIEF.md
# Peripheral Bus Cycle Generator

This block runs one read or write access at a time on a slow peripheral bus that is 8 or 16 bits wide. A requester presents an address, a direction, write data and a 20-bit timing/config word for the target device, all together with a one-clock request strobe. The block latches all of these and then steps through three timed phases: setup, strobe and hold. Chip select is held for the whole access. The read or write strobe is raised only in the strobe phase. The length of each phase comes from the config word, and reads and writes have separate fields.

When the hold phase ends, a one-clock done pulse marks completion. For a read, the data captured on the last clock of the strobe phase appears on the read data output. The config word also selects 16-bit accesses. It also selects whether the even-addressed byte travels on the upper or the lower byte lane of the bus.

Top module: `pbus_cycle_gen`

## Requirements
- R1: After reset, pb_cs, pb_rd, pb_wr, pb_wdata_oe and done are low and rdata is zero.
- R2: Chip select is high without a gap from the first setup clock to the last hold clock. A strobe is high only in the strobe phase, and the phases always run in the order setup, strobe, hold. pb_addr holds the latched address while chip select is high.
- R3: A read takes cfg[0]+1 setup clocks, cfg[4:1]+1 strobe clocks and cfg[8:5]+1 hold clocks. A field value of zero therefore gives one clock.
- R4: A write takes cfg[9]+1 setup clocks, cfg[13:10]+1 strobe clocks and cfg[17:14]+1 hold clocks.
- R5: pb_wr pulses only for writes and pb_rd only for reads. pb_wdata_oe is high on every chip-select clock of a write and low throughout a read.
- R6: done is high for exactly one clock. That clock immediately follows the last hold clock, and chip select is already low in it.
- R7: Read data is taken from pb_rdata on the last strobe clock. A bus value that changes in the hold phase does not affect rdata.
- R8: With cfg[18]=0 (8-bit), the byte is req_wdata[7:0]. It travels on pb_wdata[15:8] when cfg[19]=1 and address bit 0 is 0, and on pb_wdata[7:0] otherwise, with the other lane driven to zero. A read returns the same lane in rdata[7:0], with rdata[15:8] zero.
- R9: With cfg[18]=1 (16-bit), req_wdata[7:0] is the even byte and req_wdata[15:8] the odd byte. The even byte travels on pb_wdata[7:0] when cfg[19]=0 and on pb_wdata[15:8] when cfg[19]=1. Reads map back the same way.
- R10: A request is taken only while idle. Changes to req_valid, address, direction, data or config during an access have no effect on that access and start no further access.
- R11: A request present in the done clock is accepted, so the next access has chip select high on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Device address |
| req_wdata | input | DATA_W | Write data; [7:0] is the even byte |
| req_cfg | input | 20 | Per-device phase lengths and lane options |
| pb_addr | output | ADDR_W | Bus address |
| pb_wdata | output | DATA_W | Bus write data, lane-mapped |
| pb_wdata_oe | output | 1 | Bus write data enable |
| pb_rdata | input | DATA_W | Bus read data |
| pb_cs | output | 1 | Chip select |
| pb_rd | output | 1 | Read strobe |
| pb_wr | output | 1 | Write strobe |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Lane-mapped read data of the last read |

## Verification
The done pulse and the acceptance of a new request can fall in the same clock. The bench holds req_valid high through a done clock with a fresh request. It then expects chip select on the very next clock, with the new address on the bus. In the other disturbance tests, req_valid and all request fields toggle during an access. The bench judges these from the measured phase lengths, the bus address and the absence of chip select after done, all of which must still follow the original request.

// File: rtl/pbc_pkg.sv
// Package: shared layout of the device config word and the phase types.
// Assumes a 20-bit config word; field positions are fixed by the bus timing
// definition, counter width follows the widest phase field.
package pbc_pkg;

    localparam int CFG_W        = 20;
    localparam int SHORT_W      = 1;   // setup field width
    localparam int LONG_W       = 4;   // strobe / hold field width
    localparam int CNT_W        = LONG_W;

    localparam int RD_SETUP_LSB  = 0;
    localparam int RD_STROBE_LSB = 1;
    localparam int RD_HOLD_LSB   = 5;
    localparam int WR_SETUP_LSB  = 9;
    localparam int WR_STROBE_LSB = 10;
    localparam int WR_HOLD_LSB   = 14;
    localparam int WIDE_BIT      = 18;
    localparam int EVEN_HI_BIT   = 19;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup_len;   // extra clocks beyond one
        logic [CNT_W-1:0] strobe_len;
        logic [CNT_W-1:0] hold_len;
        logic             wide;
        logic             even_hi;
    } timing_t;

endpackage

// File: rtl/pbc_cfg_decode.sv
// Config decoder: picks the read or write phase fields out of the config
// word and extracts the lane options. Purely combinational.
// Assumes the field layout from pbc_pkg.
module pbc_cfg_decode
    import pbc_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  logic             is_write,
    output timing_t          timing
);

    // Pick direction-specific phase counts and the shared lane options.
    always_comb begin
        timing.wide    = cfg[WIDE_BIT];
        timing.even_hi = cfg[EVEN_HI_BIT];
        if (is_write) begin
            timing.setup_len  = CNT_W'(cfg[WR_SETUP_LSB +: SHORT_W]);
            timing.strobe_len = cfg[WR_STROBE_LSB +: LONG_W];
            timing.hold_len   = cfg[WR_HOLD_LSB +: LONG_W];
        end else begin
            timing.setup_len  = CNT_W'(cfg[RD_SETUP_LSB +: SHORT_W]);
            timing.strobe_len = cfg[RD_STROBE_LSB +: LONG_W];
            timing.hold_len   = cfg[RD_HOLD_LSB +: LONG_W];
        end
    end

endmodule

// File: rtl/pbc_lane_map.sv
// Byte-lane mapper between the requester's view (even byte in the low half)
// and the bus view chosen by the width and even-lane options.
// Assumes DATA_W is even; lanes are DATA_W/2 bits each.
module pbc_lane_map #(
    parameter int DATA_W = 16
) (
    input  logic              wide,
    input  logic              even_hi,
    input  logic              addr_lsb,
    input  logic [DATA_W-1:0] req_data,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] req_rdata
);

    localparam int LANE_W = DATA_W / 2;

    logic narrow_hi;
    assign narrow_hi = even_hi && !addr_lsb;

    // Place write bytes onto bus lanes.
    always_comb begin
        if (wide) begin
            bus_wdata = even_hi ? {req_data[LANE_W-1:0], req_data[DATA_W-1:LANE_W]}
                                : req_data;
        end else begin
            bus_wdata = narrow_hi ? {req_data[LANE_W-1:0], {LANE_W{1'b0}}}
                                  : {{LANE_W{1'b0}}, req_data[LANE_W-1:0]};
        end
    end

    // Gather read bytes from bus lanes.
    always_comb begin
        if (wide) begin
            req_rdata = even_hi ? {bus_rdata[LANE_W-1:0], bus_rdata[DATA_W-1:LANE_W]}
                                : bus_rdata;
        end else begin
            req_rdata = {{LANE_W{1'b0}},
                         narrow_hi ? bus_rdata[DATA_W-1:LANE_W] : bus_rdata[LANE_W-1:0]};
        end
    end

endmodule

// File: rtl/pbc_phase_seq.sv
// Phase sequencer: on start walks setup, strobe, hold, each lasting its
// field value plus one clock, then pulses done for one clock.
// Assumes the timing input is valid at start and stable for the access.
module pbc_phase_seq
    import pbc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  timing_t timing,
    output phase_e  phase,
    output logic    last,
    output logic    done
);

    logic [CNT_W-1:0] cnt;

    assign last = (cnt == '0);

    // Advance phase when the down-counter runs out; reload for the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_SETUP;
                    cnt   <= timing.setup_len;
                end
                PH_SETUP: if (last) begin
                    phase <= PH_STROBE;
                    cnt   <= timing.strobe_len;
                end else cnt <= cnt - 1'b1;
                PH_STROBE: if (last) begin
                    phase <= PH_HOLD;
                    cnt   <= timing.hold_len;
                end else cnt <= cnt - 1'b1;
                default: if (last) begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end else cnt <= cnt - 1'b1;
            endcase
        end
    end

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(phase) == PH_HOLD) && (phase == PH_IDLE)); // R6
    AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STROBE) && ($past(phase) != PH_STROBE) |-> $past(phase) == PH_SETUP); // R2
    AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) && ($past(phase) != PH_HOLD) |-> $past(phase) == PH_STROBE); // R2

endmodule

// File: rtl/pbus_cycle_gen.sv
// Top: latches one request while idle, decodes its timing, sequences the
// three phases and drives the peripheral bus; captures lane-mapped read data.
// Assumes the bus device returns read data while the read strobe is high.
module pbus_cycle_gen
    import pbc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CFG_W-1:0]  req_cfg,
    output logic [ADDR_W-1:0] pb_addr,
    output logic [DATA_W-1:0] pb_wdata,
    output logic              pb_wdata_oe,
    input  logic [DATA_W-1:0] pb_rdata,
    output logic              pb_cs,
    output logic              pb_rd,
    output logic              pb_wr,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [DATA_W-1:0] rdata_q;

    phase_e            phase;
    logic              last;
    logic              idle;
    logic              start;
    logic [CFG_W-1:0]  cfg_sel;
    logic              write_sel;
    timing_t           timing;
    logic [DATA_W-1:0] mapped_wdata;
    logic [DATA_W-1:0] mapped_rdata;

    assign idle      = (phase == PH_IDLE);
    assign start     = idle && req_valid;
    assign cfg_sel   = idle ? req_cfg   : cfg_q;
    assign write_sel = idle ? req_write : write_q;

    // Hold the accepted request for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            cfg_q   <= '0;
        end else if (start) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            wdata_q <= req_wdata;
            cfg_q   <= req_cfg;
        end
    end

    pbc_cfg_decode i_decode (
        .cfg      (cfg_sel),
        .is_write (write_sel),
        .timing   (timing)
    );

    pbc_phase_seq i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .timing (timing),
        .phase  (phase),
        .last   (last),
        .done   (done)
    );

    pbc_lane_map #(.DATA_W(DATA_W)) i_lanes (
        .wide      (timing.wide),
        .even_hi   (timing.even_hi),
        .addr_lsb  (addr_q[0]),
        .req_data  (wdata_q),
        .bus_wdata (mapped_wdata),
        .bus_rdata (pb_rdata),
        .req_rdata (mapped_rdata)
    );

    // Capture read data on the final strobe clock of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (phase == PH_STROBE && last && !write_q) rdata_q <= mapped_rdata;
    end

    assign pb_cs       = !idle;
    assign pb_rd       = (phase == PH_STROBE) && !write_q;
    assign pb_wr       = (phase == PH_STROBE) && write_q;
    assign pb_wdata_oe = pb_cs && write_q;
    assign pb_wdata    = pb_wdata_oe ? mapped_wdata : '0;
    assign pb_addr     = addr_q;
    assign rdata       = rdata_q;

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_rd || pb_wr) |-> pb_cs); // R2
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pb_rd && pb_wr)); // R5
    AST_WR_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pb_wr |-> pb_wdata_oe); // R5
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        pb_cs && $past(pb_cs) |-> $stable(cfg_q) && $stable(addr_q) && $stable(write_q)); // R10
    AST_NO_DONE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(done) && $past(pb_cs)); // R6

endmodule

// File: tb/test_pbus_cycle_gen.sv
module test_pbus_cycle_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [19:0] req_cfg = '0;
    logic [7:0]  pb_addr;
    logic [15:0] pb_wdata;
    logic        pb_wdata_oe;
    logic [15:0] pb_rdata = '0;
    logic        pb_cs, pb_rd, pb_wr, done;
    logic [15:0] rdata;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    pbus_cycle_gen i_pbus_cycle_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cfg(req_cfg),
        .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_wdata_oe(pb_wdata_oe),
        .pb_rdata(pb_rdata), .pb_cs(pb_cs), .pb_rd(pb_rd), .pb_wr(pb_wr),
        .done(done), .rdata(rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] mk_cfg(input int rs, input int rt, input int rh,
                                           input int ws, input int wt, input int wh,
                                           input bit wide, input bit ehi);
        logic [19:0] c;
        c = '0;
        c[0]     = rs[0];
        c[4:1]   = rt[3:0];
        c[8:5]   = rh[3:0];
        c[9]     = ws[0];
        c[13:10] = wt[3:0];
        c[17:14] = wh[3:0];
        c[18]    = wide;
        c[19]    = ehi;
        return c;
    endfunction

    function automatic logic [15:0] exp_bus(input logic [15:0] wd, input logic [19:0] c,
                                            input logic a0);
        if (c[18]) return c[19] ? {wd[7:0], wd[15:8]} : wd;
        return (c[19] && !a0) ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]};
    endfunction

    function automatic logic [15:0] exp_rd(input logic [15:0] bus, input logic [19:0] c,
                                           input logic a0);
        if (c[18]) return c[19] ? {bus[7:0], bus[15:8]} : bus;
        return {8'h00, (c[19] && !a0) ? bus[15:8] : bus[7:0]};
    endfunction

    // One access, measured phase by phase at the falling edge.
    task automatic do_cycle(input string lane_req, input bit wr, input logic [7:0] a,
                            input logic [15:0] wd, input logic [19:0] c,
                            input logic [15:0] rbus, input bit disturb);
        int e_s, e_t, e_h;
        int pre, stb, post, bad_strobe, bad_data, n;
        logic [15:0] ew, er;
        string len_req;
        e_s = wr ? int'(c[9]) + 1     : int'(c[0]) + 1;
        e_t = wr ? int'(c[13:10]) + 1 : int'(c[4:1]) + 1;
        e_h = wr ? int'(c[17:14]) + 1 : int'(c[8:5]) + 1;
        len_req = wr ? "R4" : "R3";
        ew = exp_bus(wd, c, a[0]);
        er = exp_rd(rbus, c, a[0]);
        pre = 0; stb = 0; post = 0; bad_strobe = 0; bad_data = 0; n = 0;
        @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = wd; req_cfg = c; req_valid = 1'b1;
        pb_rdata = ~rbus;
        @(negedge clk);
        if (disturb) begin
            req_addr = ~a; req_write = ~wr; req_wdata = ~wd; req_cfg = 20'hFFFFF;
        end else req_valid = 1'b0;
        while (pb_cs && n < 100) begin
            if (pb_rd || pb_wr) stb++;
            else if (stb == 0) pre++;
            else post++;
            if ((wr && pb_rd) || (!wr && pb_wr)) bad_strobe++;
            if (pb_addr !== a || pb_wdata_oe !== wr || (wr && pb_wdata !== ew) || done)
                bad_data++;
            pb_rdata = pb_rd ? rbus : ~rbus;
            if (disturb && n == 1) req_valid = 1'b0;
            if (disturb && n == 2) req_valid = 1'b1;
            n++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        pb_rdata = ~rbus;
        check(pre == e_s, len_req, "setup clocks", pre, e_s);
        check(stb == e_t, len_req, "strobe clocks", stb, e_t);
        check(post == e_h, len_req, "hold clocks", post, e_h);
        check(bad_strobe == 0, "R5", "wrong strobe type", bad_strobe, 0);
        check(bad_data == 0, wr ? lane_req : "R2", "addr/data/oe during cs", bad_data, 0);
        check(done === 1'b1, "R6", "done after hold", int'(done), 1);
        if (!wr) check(rdata === er, lane_req, "read data (R7 sample point)", rdata, er);
        @(negedge clk);
        check(done === 1'b0, "R6", "done width", int'(done), 0);
        check(pb_cs === 1'b0, disturb ? "R10" : "R2", "cs after done", int'(pb_cs), 0);
    endtask

    // Request held through the done clock must start at once.
    task automatic test_back_to_back();
        int n;
        @(negedge clk);
        req_write = 1'b0; req_addr = 8'h10; req_cfg = 20'h0; req_valid = 1'b1;
        n = 0;
        @(negedge clk);
        while (pb_cs && n < 20) begin n++; @(negedge clk); end
        check(done === 1'b1, "R11", "done of first access", int'(done), 1);
        req_write = 1'b1; req_addr = 8'h2B; req_wdata = 16'h00C4;
        @(negedge clk);
        req_valid = 1'b0;
        check(pb_cs === 1'b1, "R11", "cs right after done", int'(pb_cs), 1);
        check(pb_addr === 8'h2B, "R11", "second address", pb_addr, 8'h2B);
        n = 0;
        while (pb_cs && n < 20) begin n++; @(negedge clk); end
        check(n == 3, "R11", "second access clocks", n, 3);
        @(negedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(pb_cs === 1'b0, "R1", "pb_cs", int'(pb_cs), 0);
        check(pb_rd === 1'b0, "R1", "pb_rd", int'(pb_rd), 0);
        check(pb_wr === 1'b0, "R1", "pb_wr", int'(pb_wr), 0);
        check(pb_wdata_oe === 1'b0, "R1", "pb_wdata_oe", int'(pb_wdata_oe), 0);
        check(done === 1'b0, "R1", "done", int'(done), 0);
        check(rdata === 16'h0, "R1", "rdata", rdata, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        // R3 minimum lengths, R8 narrow read low lane
        do_cycle("R8", 1'b0, 8'h40, 16'h0, mk_cfg(0,0,0, 1,7,7, 0,0), 16'h5A3C, 0);
        // R3 long read lengths, R8 narrow read high lane (even addr, even-high)
        do_cycle("R8", 1'b0, 8'h42, 16'h0, mk_cfg(1,15,9, 0,0,0, 0,1), 16'h9E17, 0);
        // R8 narrow read, odd address with even-high: low lane
        do_cycle("R8", 1'b0, 8'h43, 16'h0, mk_cfg(0,2,1, 0,0,0, 0,1), 16'h9E17, 0);
        // R4 write lengths, R8 narrow write odd addr -> low lane
        do_cycle("R8", 1'b1, 8'h11, 16'hBE71, mk_cfg(0,0,0, 1,3,14, 0,1), 16'h0, 0);
        // R8 narrow write even addr with even-high -> high lane
        do_cycle("R8", 1'b1, 8'h12, 16'hBE71, mk_cfg(1,5,5, 0,15,0, 0,1), 16'h0, 0);
        // R9 wide write, both lane orders
        do_cycle("R9", 1'b1, 8'h20, 16'h1234, mk_cfg(0,0,0, 0,2,2, 1,0), 16'h0, 0);
        do_cycle("R9", 1'b1, 8'h22, 16'h1234, mk_cfg(0,0,0, 1,1,3, 1,1), 16'h0, 0);
        // R9 wide read, both lane orders
        do_cycle("R9", 1'b0, 8'h24, 16'h0, mk_cfg(1,3,2, 0,0,0, 1,0), 16'hC0DE, 0);
        do_cycle("R9", 1'b0, 8'h26, 16'h0, mk_cfg(0,4,0, 0,0,0, 1,1), 16'hC0DE, 0);
        // R10 inputs toggled during read and write
        do_cycle("R8", 1'b0, 8'h30, 16'h0, mk_cfg(0,2,3, 0,0,0, 0,0), 16'h0077, 1);
        do_cycle("R9", 1'b1, 8'h31, 16'hA55A, mk_cfg(0,0,0, 1,2,4, 1,1), 16'h0, 1);
        test_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule